// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a multiplying DAC. A host writes 16-bit words over a three-wire serial link: a serial clock, an active-low frame strobe and a data line. Each word carries a 4-bit command nibble followed by a 12-bit data field, and is sent most significant bit first. When the strobe returns high after a complete word, the block decodes the nibble. It can then load or clear the DAC register, change how the serial port behaves, or arm a readback. The DAC register drives a parallel 12-bit output bus that feeds the analog converter.

All serial pins are sampled by a fast system clock, and serial-clock edges are detected against that clock. A serial output serves two purposes. With chaining on, it passes the input stream on to a downstream device, delayed by one full word. On the frame after a readback command, it shifts out the DAC register contents.

Top module: `dac_ser_ctrl`

## Requirements
- R1: A frame opens when `sync_ni` falls and closes when it rises. Only a frame with exactly 16 active serial-clock edges is decoded: bits [15:12] are the command and bits [11:0] are the data, first bit received = bit 15. A frame with 15 or 17 edges changes nothing.
- R2: After reset, capture uses falling `sclk_i` edges, chaining is on, `dac_o` is 0 and `sdo_o` is 0.
- R3: Command 0x0 leaves `dac_o` and the port configuration unchanged.
- R4: Command 0x1 copies the data field to `dac_o`.
- R5: Command 0x2 arms a readback. During the next frame, `sdo_o` sampled before active edge k (k = 0..15) equals bit 15-k of {4'b0000, dac_o}.
- R6: Command 0x9 turns chaining off. From then on, `sdo_o` stays 0 except during a readback frame.
- R7: Command 0xA makes rising `sclk_i` edges the active ones. No command turns this back.
- R8: Command 0xB clears `dac_o` to 0x000. Command 0xC sets `dac_o` to midscale, 0x800.
- R9: Commands 0x3-0x8 and 0xD-0xF change neither `dac_o` nor the configuration.
- R10: With chaining on, `sdo_o` sampled before active edge k equals the bit that was shifted in 16 active edges earlier. This is bit 15-k of the previous frame's word, or of the readback image if a readback was loaded.
- R11: `dac_o` changes only in response to the close of a valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all serial pins sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sync_ni | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Chain / readback serial data out |
| dac_o | output | 12 | DAC register value |

## Verification
Most internal faults surface at `sdo_o` within one frame. A wrong shift register, edge count or active-edge choice puts a wrong bit there by the next active edge, because every bit is compared while chaining is on. A wrong command decode or clear value shows on `dac_o` two system clocks after the strobe rises. A lost readback flag or chain flag becomes visible on the first bit of the following frame.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'h0,
    CMD_LOAD      = 4'h1,
    CMD_RDBK      = 4'h2,
    CMD_CHAIN_OFF = 4'h9,
    CMD_RISE      = 4'hA,
    CMD_ZERO      = 4'hB,
    CMD_MID       = 4'hC
  } cmd_e;
endpackage

// File: rtl/dac_ser_edge.sv
module dac_ser_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sync_ni,
  input  logic rise_mode_i,
  output logic shift_en_o,
  output logic frame_start_o,
  output logic frame_end_o
);
  logic sclk_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      sync_q <= sync_ni;
    end
  end

  logic sclk_rise, sclk_fall;
  assign sclk_rise     = sclk_i & ~sclk_q;
  assign sclk_fall     = ~sclk_i & sclk_q;
  assign frame_start_o = sync_q & ~sync_ni;
  assign frame_end_o   = ~sync_q & sync_ni;
  // start cycle reserved for readback preload
  assign shift_en_o    = ~sync_ni & ~frame_start_o &
                         (rise_mode_i ? sclk_rise : sclk_fall);
endmodule

// File: rtl/dac_ser_shift.sv
module dac_ser_shift #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_en_i,
  input  logic                    frame_start_i,
  input  logic                    rb_load_i,
  input  logic                    sdin_i,
  input  logic [DATA_W-1:0]       rb_data_i,
  output logic [CMD_W+DATA_W-1:0] word_o,
  output logic                    cnt_ok_o
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (frame_start_i) begin
      cnt_q <= '0;
      if (rb_load_i) sh_q <= {{CMD_W{1'b0}}, rb_data_i};
    end else if (shift_en_i) begin
      sh_q <= {sh_q[FRAME_W-2:0], sdin_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o   = sh_q;
  assign cnt_ok_o = (cnt_q == CNT_W'(FRAME_W));
endmodule

// File: rtl/dac_ser_cfg.sv
module dac_ser_cfg
  import dac_ser_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_start_i,
  input  logic                    frame_end_i,
  input  logic                    cnt_ok_i,
  input  logic [CMD_W+DATA_W-1:0] word_i,
  output logic [DATA_W-1:0]       dac_o,
  output logic                    chain_en_o,
  output logic                    rise_mode_o,
  output logic                    rb_load_o,
  output logic                    rb_act_o
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam logic [DATA_W-1:0] MID_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  cmd_e        cmd;
  logic        rb_pend_q;
  logic        valid_end;

  assign cmd       = cmd_e'(word_i[FRAME_W-1 -: CMD_W]);
  assign valid_end = frame_end_i & cnt_ok_i;
  assign rb_load_o = frame_start_i & rb_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_o       <= '0;
      chain_en_o  <= 1'b1;
      rise_mode_o <= 1'b0;
      rb_pend_q   <= 1'b0;
      rb_act_o    <= 1'b0;
    end else begin
      if (rb_load_o) begin
        rb_pend_q <= 1'b0;
        rb_act_o  <= 1'b1;
      end
      if (frame_end_i) rb_act_o <= 1'b0;
      if (valid_end) begin
        unique case (cmd)
          CMD_LOAD:      dac_o       <= word_i[DATA_W-1:0];
          CMD_RDBK:      rb_pend_q   <= 1'b1;
          CMD_CHAIN_OFF: chain_en_o  <= 1'b0;
          CMD_RISE:      rise_mode_o <= 1'b1;
          CMD_ZERO:      dac_o       <= '0;
          CMD_MID:       dac_o       <= MID_VAL;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_ser_ctrl.sv
module dac_ser_ctrl #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              sdin_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] dac_o
);
  localparam int CMD_W   = dac_ser_pkg::CMD_W;
  localparam int FRAME_W = CMD_W + DATA_W;

  logic               shift_en, frame_start, frame_end, cnt_ok;
  logic               chain_en, rise_mode, rb_load, rb_act;
  logic [FRAME_W-1:0] word;

  dac_ser_edge u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sclk_i        (sclk_i),
    .sync_ni       (sync_ni),
    .rise_mode_i   (rise_mode),
    .shift_en_o    (shift_en),
    .frame_start_o (frame_start),
    .frame_end_o   (frame_end)
  );

  dac_ser_shift #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .shift_en_i    (shift_en),
    .frame_start_i (frame_start),
    .rb_load_i     (rb_load),
    .sdin_i        (sdin_i),
    .rb_data_i     (dac_o),
    .word_o        (word),
    .cnt_ok_o      (cnt_ok)
  );

  dac_ser_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .frame_end_i   (frame_end),
    .cnt_ok_i      (cnt_ok),
    .word_i        (word),
    .dac_o         (dac_o),
    .chain_en_o    (chain_en),
    .rise_mode_o   (rise_mode),
    .rb_load_o     (rb_load),
    .rb_act_o      (rb_act)
  );

  assign sdo_o = (chain_en | rb_act) & word[FRAME_W-1];
endmodule

// File: rtl/dac_ser_chk.sv
module dac_ser_chk #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_end_i,
  input logic               cnt_ok_i,
  input logic [FRAME_W-1:0] word_i,
  input logic [DATA_W-1:0]  dac_i,
  input logic               chain_en_i,
  input logic               rise_mode_i
);
  logic [3:0] cmd;
  logic       valid_end, rsvd;
  assign cmd       = word_i[FRAME_W-1 -: 4];
  assign valid_end = frame_end_i & cnt_ok_i;
  assign rsvd      = (cmd >= 4'h3 && cmd <= 4'h8) || (cmd >= 4'hD);

  a_r11_dac_moves_on_frame_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_i) |-> $past(valid_end));

  a_r4_load_copies_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_end && cmd == 4'h1) |=> dac_i == $past(word_i[DATA_W-1:0]));

  a_r8_midscale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_end && cmd == 4'hC) |=> dac_i == {1'b1, {(DATA_W-1){1'b0}}});

  a_r8_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_end && cmd == 4'hB) |=> dac_i == '0);

  a_r9_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_end && rsvd) |=> $stable(dac_i) && $stable(chain_en_i) && $stable(rise_mode_i));

  a_r6_chain_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_en_i |=> !chain_en_i);

  a_r7_rise_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_mode_i |=> rise_mode_i);
endmodule

bind dac_ser_ctrl dac_ser_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_end_i (frame_end),
  .cnt_ok_i    (cnt_ok),
  .word_i      (word),
  .dac_i       (dac_o),
  .chain_en_i  (chain_en),
  .rise_mode_i (rise_mode)
);

// File: tb/sim_dac_ser_ctrl.sv
module sim_dac_ser_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0;
  logic        sdo;
  logic [11:0] dac;

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [15:0] m_sh = '0;
  logic [11:0] m_dac = '0;
  bit          m_chain = 1'b1, m_rise = 1'b0, m_pend = 1'b0, m_ract = 1'b0;

  always #2 clk = ~clk;

  dac_ser_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sync_ni(sync_n),
    .sdin_i(sdin), .sdo_o(sdo), .dac_o(dac)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input string req);
    logic idle;
    idle = m_rise ? 1'b0 : 1'b1;
    sclk = idle;
    tick(2);
    sync_n = 1'b0;
    if (m_pend) begin
      m_pend = 1'b0; m_ract = 1'b1; m_sh = {4'b0000, m_dac};
    end
    tick(2);
    for (int k = 0; k < nbits; k++) begin
      sdin = (k < 16) ? w[15-k] : 1'b0;
      tick(2);
      // R10 / R5 / R6: serial out before each active edge
      check({req, " sdo (R5 R6 R10)"}, {15'b0, sdo},
            {15'b0, (m_chain | m_ract) & m_sh[15]});
      sclk = ~idle;
      m_sh = {m_sh[14:0], sdin};
      tick(2);
      sclk = idle;
    end
    tick(2);
    sync_n = 1'b1;
    m_ract = 1'b0;
    if (nbits == 16) begin
      case (w[15:12])
        4'h1: m_dac = w[11:0];
        4'h2: m_pend = 1'b1;
        4'h9: m_chain = 1'b0;
        4'hA: m_rise = 1'b1;
        4'hB: m_dac = '0;
        4'hC: m_dac = 12'h800;
        default: ;
      endcase
    end
    tick(2);
    check({req, " dac"}, {4'b0, dac}, {4'b0, m_dac});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    check("R2 reset dac", {4'b0, dac}, 16'h0000);
    check("R2 reset sdo", {15'b0, sdo}, 16'h0000);

    // R4 + R10: loads with chained output, falling edges (R2)
    for (int v = 0; v < 24; v++)
      send({4'h1, 12'(v * 12'h1A7 + 12'h05C)}, 16, "R4 load");
    send(16'h1FFF, 16, "R4 load all-ones");
    send(16'h1000, 16, "R4 load zero");
    send(16'h1ABC, 16, "R4 load");

    send(16'h0123, 16, "R3 nop");

    // R9: every reserved code
    for (int c = 3; c <= 15; c++)
      if (c <= 8 || c >= 13) send({4'(c), 12'hF0F}, 16, "R9 reserved");

    // R1: wrong edge counts discarded
    send(16'h1555, 15, "R1 short frame");
    send(16'h1555, 17, "R1 long frame");
    send(16'h1321, 16, "R1 exact frame");

    // R5: readback then next frame
    send(16'h2000, 16, "R5 arm");
    send(16'h0000, 16, "R5 readback frame");

    // R8 clears
    send(16'h1777, 16, "R4 load");
    send(16'hC000, 16, "R8 midscale");
    send(16'hB000, 16, "R8 zero");
    send(16'hC3FF, 16, "R8 midscale");

    // R6: chaining off, readback still shown
    send(16'h9000, 16, "R6 chain off");
    send(16'h1F0F, 16, "R6 quiet");
    send(16'h2000, 16, "R6 arm");
    send(16'h0000, 16, "R6 readback frame");
    send(16'h0FFF, 16, "R6 quiet");

    // R7: rising edge capture
    send(16'hA000, 16, "R7 rise");
    sclk = 1'b0;
    tick(2);
    for (int v = 0; v < 8; v++)
      send({4'h1, 12'(v * 12'h2D3 + 12'h111)}, 16, "R7 rise load");
    send(16'h2000, 16, "R7 arm");
    send(16'h1456, 16, "R7 readback frame");
    send(16'hC000, 16, "R7 midscale");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule